// File: doc/BRIEF.md
# Serial Port Interrupt and Power-Mode Controller

This block gathers the event strobes of a UART-style serial port into eight sticky status flags. Each flag is masked by its own enable bit, and the results are combined into one registered, level-sensitive interrupt request. Six of the events arrive as one-cycle pulses from the transmitter and receiver datapaths: transmit buffer empty, transmit finished, receive buffer full, overrun, idle line and break detected. The other two are produced inside the block. One is a receive-line active-edge detector with selectable polarity. The other is a single-wire bit-error comparator that matches the bit being sent against the level read back from the line.

The block also takes the CPU wait and stop indications and turns them into a serial clock enable for the baud and shift logic, which lie outside the block. In wait mode the clock keeps running unless the freeze-in-wait control bit is set. In stop mode the clock is always gated off, while flags and control state are kept. Throughout both modes the edge detector keeps watching the receive line, and it raises a wake request when an edge is seen. A reset taken while in wait or stop raises an abort strobe for the transfer logic and clears the whole block. Software reaches the block through a simple write port with three targets: enables, flag clear and control.

Top module: `sirq_ctrl`

## Requirements
- R1: While reset is high, the flags, enables, irq_o, wake_o, sclk_en_o, rx_en_o and tx_en_o are all 0. sclk_en_o rises on the first clock edge after reset is released when neither wait nor stop is active.
- R2: Flag bit order is 0 tx empty, 1 tx done, 2 rx full, 3 overrun, 4 idle, 5 break, 6 rx edge, 7 bit error. ext_ev_i[5:0] drive flags 5..0 directly. A pulse sets its flag on the next edge. Writing wr_sel_i=1 clears every flag whose wr_data_i bit is 1 on the next edge and leaves the other flags unchanged.
- R3: If a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R4: irq_o is 1 exactly one cycle after any flag is 1 together with its enable bit (written with wr_sel_i=0). It stays high as long as that is true and drops one cycle after it stops being true.
- R5: Control bit 1 (wr_sel_i=2) selects the edge polarity: 0 detects a falling edge of rxd_i, 1 detects a rising edge. The opposite edge is ignored. With two synchronizer stages, flag 6 is set 3 cycles after rxd_i changes.
- R6: When control bit 2 (single-wire) is 1, a bit_smp_i strobe with tx_bit_i different from the synchronized line sets flag 7 on the next edge. With the levels equal, or with bit 2 at 0, the strobe does nothing.
- R7: When control bit 0 (freeze-in-wait) is 0, sclk_en_o stays 1 during wait_i. When it is 1, sclk_en_o drops one cycle after wait_i rises and comes back one cycle after wait_i falls.
- R8: stop_i forces sclk_en_o to 0 one cycle later, whatever the control bits. Flags and control are kept during stop, and sclk_en_o returns one cycle after stop_i falls.
- R9: An edge on the receive line is still detected during stop. wake_o goes high one cycle after flag 6 is set while stop_i or wait_i is high.
- R10: Control bits 3 (receiver enable, rx_en_o) and 4 (transmitter enable, tx_en_o) change only through a control write. Entering wait or stop never changes them.
- R11: A reset taken while wait_i or stop_i is high drives abort_o to 1 one cycle later and clears all flags, enables and control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_ev_i | input | 6 | One-cycle datapath event pulses for flags 5..0 |
| rxd_i | input | 1 | Receive line level (asynchronous) |
| tx_bit_i | input | 1 | Bit currently being driven in single-wire mode |
| bit_smp_i | input | 1 | Strobe to compare tx_bit_i with the line |
| wait_i | input | 1 | CPU wait mode active |
| stop_i | input | 1 | CPU stop mode active |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 enables, 1 flag clear, 2 control |
| wr_data_i | input | 8 | Write data |
| flags_o | output | 8 | Status flags |
| ena_o | output | 8 | Interrupt enable bits |
| rx_en_o | output | 1 | Receiver enable control bit |
| tx_en_o | output | 1 | Transmitter enable control bit |
| irq_o | output | 1 | Level interrupt request |
| wake_o | output | 1 | Wake request from receive edge in low-power mode |
| sclk_en_o | output | 1 | Serial clock enable for baud and shift logic |
| abort_o | output | 1 | Transfer abort strobe on reset out of wait or stop |

## Verification
The latencies are fixed. Flags, enables, control bits, sclk_en_o and abort_o respond one edge after their stimulus. irq_o responds two edges after an event pulse, and wake_o one edge after its flag. A receive-line change reaches flag 6 after three edges and irq_o or wake_o after four. Each stimulus task records its expected value tagged with the cycle in which it is due. A monitor runs on the falling clock edge and compares an item only in that exact cycle. The driver leaves enough idle cycles after every edge stimulus that no later input can disturb a pending result.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int NSRC = 8;
    localparam int NEXT = NSRC - 2;

    typedef enum logic [2:0] {
        SRC_TXE  = 3'd0,
        SRC_TXC  = 3'd1,
        SRC_RXF  = 3'd2,
        SRC_OVR  = 3'd3,
        SRC_IDLE = 3'd4,
        SRC_BRK  = 3'd5,
        SRC_EDGE = 3'd6,
        SRC_BERR = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        SEL_ENA = 2'd0,
        SEL_CLR = 2'd1,
        SEL_CTL = 2'd2
    } wsel_e;

    // bit 4 tx_en, 3 rx_en, 2 one_wire, 1 rx_pol, 0 wait_frz
    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic one_wire;
        logic rx_pol;
        logic wait_frz;
    } ctl_t;

    localparam int CTLW = $bits(ctl_t);

    function automatic ctl_t ctl_from(input logic [7:0] d);
        return ctl_t'(d[CTLW-1:0]);
    endfunction
endpackage

// File: rtl/sirq_edge_det.sv
module sirq_edge_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_i,
    input  logic pol_i,
    output logic line_o,
    output logic edge_o
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;

    generate
        if (SYNC == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rxd_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC-2:0], rxd_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= line_o;
    end

    assign line_o = sync_q[SYNC-1];
    assign edge_o = pol_i ? (line_o & ~prev_q) : (~line_o & prev_q);

    // R5: a rise seen with polarity 1 must report an edge
    a_r5_rise_seen: assert property (@(posedge clk) disable iff (rst)
        (pol_i && $rose(line_o)) |-> edge_o);
    // R5: the ignored direction never reports
    a_r5_fall_ignored: assert property (@(posedge clk) disable iff (rst)
        (pol_i && $fell(line_o)) |-> !edge_o);
endmodule

// File: rtl/sirq_flag_bank.sv
module sirq_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst)           q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
        end
        assign flag_o[i] = q;

        a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_o[i]);
        a_r2_clear_bit: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
        a_r2_hold_bit: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
    end
endmodule

// File: rtl/sirq_pwr.sv
module sirq_pwr (
    input  logic clk,
    input  logic rst,
    input  logic wait_i,
    input  logic stop_i,
    input  logic wait_frz_i,
    output logic sclk_en_o,
    output logic abort_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_en_o <= 1'b0;
            abort_o   <= wait_i | stop_i;
        end else begin
            sclk_en_o <= !stop_i && !(wait_i && wait_frz_i);
            abort_o   <= 1'b0;
        end
    end

    a_r8_stop_gates: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !sclk_en_o);
    a_r7_wait_runs: assert property (@(posedge clk) disable iff (rst)
        (wait_i && !wait_frz_i && !stop_i) |=> sclk_en_o);
    a_r7_wait_frozen: assert property (@(posedge clk) disable iff (rst)
        (wait_i && wait_frz_i) |=> !sclk_en_o);
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] ext_ev_i,
    input  logic            rxd_i,
    input  logic            tx_bit_i,
    input  logic            bit_smp_i,
    input  logic            wait_i,
    input  logic            stop_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic [7:0]      wr_data_i,
    output logic [NSRC-1:0] flags_o,
    output logic [NSRC-1:0] ena_o,
    output logic            rx_en_o,
    output logic            tx_en_o,
    output logic            irq_o,
    output logic            wake_o,
    output logic            sclk_en_o,
    output logic            abort_o
);
    ctl_t            ctl_q;
    logic [NSRC-1:0] ena_q;
    logic            irq_q;
    logic            wake_q;
    logic            line;
    logic            edge_ev;
    logic            berr_ev;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic            wr_ctl;

    assign wr_ctl  = wr_en_i && (wr_sel_i == SEL_CTL);
    assign clr_v   = (wr_en_i && (wr_sel_i == SEL_CLR)) ? wr_data_i : '0;
    assign berr_ev = ctl_q.one_wire && bit_smp_i && (tx_bit_i != line);
    assign set_v   = {berr_ev, edge_ev, ext_ev_i};

    sirq_edge_det #(.SYNC(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .rxd_i  (rxd_i),
        .pol_i  (ctl_q.rx_pol),
        .line_o (line),
        .edge_o (edge_ev)
    );

    sirq_flag_bank #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .flag_o (flags_o)
    );

    sirq_pwr u_pwr (
        .clk        (clk),
        .rst        (rst),
        .wait_i     (wait_i),
        .stop_i     (stop_i),
        .wait_frz_i (ctl_q.wait_frz),
        .sclk_en_o  (sclk_en_o),
        .abort_o    (abort_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            ena_q  <= '0;
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            if (wr_ctl) ctl_q <= ctl_from(wr_data_i);
            if (wr_en_i && (wr_sel_i == SEL_ENA)) ena_q <= wr_data_i;
            irq_q  <= |(flags_o & ena_q);
            wake_q <= (stop_i || wait_i) && flags_o[SRC_EDGE];
        end
    end

    assign ena_o   = ena_q;
    assign rx_en_o = ctl_q.rx_en;
    assign tx_en_o = ctl_q.tx_en;
    assign irq_o   = irq_q;
    assign wake_o  = wake_q;

    a_r4_irq_raise: assert property (@(posedge clk) disable iff (rst)
        (|(flags_o & ena_o)) |=> irq_o);
    a_r4_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        !(|(flags_o & ena_o)) |=> !irq_o);
    a_r9_wake_stop: assert property (@(posedge clk) disable iff (rst)
        (stop_i && flags_o[SRC_EDGE]) |=> wake_o);
    a_r10_en_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ctl |=> $stable({rx_en_o, tx_en_o}));
    a_r6_berr_gated: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.one_wire && !flags_o[SRC_BERR] && !clr_v[SRC_BERR]) |=> !flags_o[SRC_BERR]);
endmodule

// File: tb/tb_sirq_ctrl.sv
`timescale 1ns/1ps
module tb_sirq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] ext_ev = '0;
    logic       rxd = 1'b1, tx_bit = 1'b0, bit_smp = 1'b0;
    logic       wait_m = 1'b0, stop_m = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] flags, ena;
    logic       rx_en, tx_en, irq, wake, sclk_en, abort_s;

    always #2.5 clk = ~clk;

    sirq_ctrl dut (
        .clk(clk), .rst(rst), .ext_ev_i(ext_ev), .rxd_i(rxd), .tx_bit_i(tx_bit),
        .bit_smp_i(bit_smp), .wait_i(wait_m), .stop_i(stop_m), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .flags_o(flags), .ena_o(ena),
        .rx_en_o(rx_en), .tx_en_o(tx_en), .irq_o(irq), .wake_o(wake),
        .sclk_en_o(sclk_en), .abort_o(abort_s)
    );

    localparam int S_FL = 0, S_IRQ = 1, S_CLK = 2, S_WAKE = 3, S_ABT = 4, S_EN = 5, S_ENA = 6;

    typedef struct {
        int         due;
        int         sig;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] get(int s);
        case (s)
            S_FL:    return flags;
            S_IRQ:   return {7'd0, irq};
            S_CLK:   return {7'd0, sclk_en};
            S_WAKE:  return {7'd0, wake};
            S_ABT:   return {7'd0, abort_s};
            S_EN:    return {6'd0, rx_en, tx_en};
            default: return ena;
        endcase
    endfunction

    // monitor: compares each item in its due cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                total++;
                if (get(q[i].sig) !== q[i].val) begin
                    bad++;
                    $display("FAIL %s sig=%0d actual=%0h expected=%0h",
                             q[i].req, q[i].sig, get(q[i].sig), q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic chk(int s, logic [7:0] v, int lat, string req);
        exp_t e;
        e.due = cyc + lat; e.sig = s; e.val = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic ev(logic [5:0] v);
        ext_ev = v;
        step();
        ext_ev = '0;
    endtask

    task automatic smp(logic b);
        tx_bit = b; bit_smp = 1'b1;
        step();
        bit_smp = 1'b0;
    endtask

    initial begin
        idle(2);
        // R1 reset state
        chk(S_FL, 8'h00, 1, "R1"); chk(S_IRQ, 0, 1, "R1");
        chk(S_CLK, 0, 1, "R1");    chk(S_EN, 0, 1, "R1");
        chk(S_WAKE, 0, 1, "R1");
        step();
        rst = 1'b0;
        chk(S_CLK, 1, 1, "R1");
        idle(2);

        // R2 / R4 set, clear, level irq
        wr(2'd0, 8'hFF);
        chk(S_FL, 8'h05, 1, "R2"); chk(S_IRQ, 1, 2, "R4");
        ev(6'b000101);
        idle(2);
        chk(S_FL, 8'h04, 1, "R2"); chk(S_IRQ, 1, 2, "R4");
        wr(2'd1, 8'h01);
        idle(2);
        chk(S_FL, 8'h00, 1, "R2"); chk(S_IRQ, 0, 2, "R4");
        wr(2'd1, 8'h04);
        idle(3);

        // R3 set beats clear in the same cycle
        ext_ev = 6'b001000;
        chk(S_FL, 8'h08, 1, "R3");
        wr(2'd1, 8'h08);
        ext_ev = '0;
        idle(2);
        wr(2'd1, 8'hFF);
        idle(2);

        // R4 masking
        wr(2'd0, 8'h00);
        chk(S_FL, 8'h20, 1, "R2"); chk(S_IRQ, 0, 2, "R4");
        ev(6'b100000);
        idle(2);
        chk(S_ENA, 8'h20, 1, "R4"); chk(S_IRQ, 1, 2, "R4");
        wr(2'd0, 8'h20);
        idle(2);
        chk(S_IRQ, 0, 2, "R4");
        wr(2'd1, 8'h20);
        idle(3);

        // R5 polarity 0: falling detected, rising ignored
        rxd = 1'b0; chk(S_FL, 8'h40, 3, "R5");
        idle(4);
        wr(2'd1, 8'h40);
        idle(1);
        rxd = 1'b1; chk(S_FL, 8'h00, 4, "R5");
        idle(5);
        wr(2'd2, 8'h02);
        idle(1);
        rxd = 1'b0; chk(S_FL, 8'h00, 4, "R5");
        idle(5);
        rxd = 1'b1; chk(S_FL, 8'h40, 3, "R5");
        idle(4);
        wr(2'd1, 8'h40);
        idle(2);

        // R6 single-wire bit error
        chk(S_FL, 8'h00, 1, "R6");
        smp(1'b0);
        idle(1);
        wr(2'd2, 8'h06);
        chk(S_FL, 8'h00, 1, "R6");
        smp(1'b1);
        chk(S_FL, 8'h80, 1, "R6");
        smp(1'b0);
        idle(1);
        wr(2'd1, 8'h80);
        idle(2);

        // R7 / R10 wait behaviour
        chk(S_EN, 8'h03, 1, "R10");
        wr(2'd2, 8'h18);
        idle(1);
        wait_m = 1'b1; chk(S_CLK, 1, 1, "R7");
        idle(3);
        wait_m = 1'b0;
        idle(1);
        wr(2'd2, 8'h19);
        wait_m = 1'b1; chk(S_CLK, 0, 1, "R7"); chk(S_EN, 8'h03, 2, "R10");
        idle(3);
        wait_m = 1'b0; chk(S_CLK, 1, 1, "R7");
        idle(2);

        // R8 / R9 stop, flags kept, edge wake
        wr(2'd0, 8'h40);
        chk(S_FL, 8'h02, 1, "R2");
        ev(6'b000010);
        stop_m = 1'b1; chk(S_CLK, 0, 1, "R8"); chk(S_EN, 8'h03, 1, "R10");
        idle(3);
        chk(S_FL, 8'h02, 1, "R8");
        rxd = 1'b0;
        chk(S_FL, 8'h42, 3, "R9"); chk(S_WAKE, 1, 4, "R9"); chk(S_IRQ, 1, 4, "R9");
        idle(6);
        stop_m = 1'b0; chk(S_CLK, 1, 1, "R8"); chk(S_WAKE, 0, 1, "R9");
        rxd = 1'b1;
        idle(5);
        chk(S_FL, 8'h00, 1, "R2"); chk(S_IRQ, 0, 2, "R4");
        wr(2'd1, 8'h42);
        idle(3);

        // R11 reset out of stop
        ev(6'b000001);
        stop_m = 1'b1;
        idle(2);
        rst = 1'b1;
        chk(S_ABT, 1, 1, "R11"); chk(S_FL, 8'h00, 1, "R11");
        chk(S_ENA, 8'h00, 1, "R11"); chk(S_EN, 8'h00, 1, "R11");
        chk(S_CLK, 0, 1, "R11");
        step();
        rst = 1'b0; stop_m = 1'b0;
        chk(S_ABT, 0, 1, "R11"); chk(S_CLK, 1, 1, "R1");
        idle(6);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule